// File: doc/BRIEF.md
# SPI slave command responder

This block is an SPI slave for a command/response link to a host master. It runs in SPI mode 1 with 8-bit frames. Bytes from the host are gathered into fixed 4-byte commands. A command reaches the local command port only once its fourth byte has arrived. Local logic answers by pushing response bytes into a small transmit FIFO. When a response ends it marks the final byte, and the block then raises an interrupt line to the host. The host reacts by selecting the slave and clocking out the reply while it sends 0x00 filler bytes. An acknowledge reply is normally 0xA5.

All SPI pins are brought into the system clock domain through synchronisers and sampled there. If a frame starts while the transmit FIFO holds nothing, the block sends the last byte it transmitted again and records a sticky underrun. Received bytes wait in an 8-byte receive store. A command that is cut short by chip select, or by a full store, is thrown away as a whole. Decoding of the commands belongs to the local logic.

Top module: `spi_cmd_responder`

## Requirements
- R1: SPI mode 1, MSB first. MOSI is sampled on falling SCLK edges and MISO changes only after rising SCLK edges. A frame's first rising edge loads the byte to be sent.
- R2: A frame is 8 SCLK periods. A received byte is complete at the 8th falling edge while chip select (active low) stays low.
- R3: Each group of 4 received bytes forms one command on `cmd_data`, with the first byte in bits 31:24 and the last in bits 7:0. `cmd_valid` rises only after the 4th byte and holds with stable data until a cycle with `cmd_ready` high.
- R4: Response bytes leave on MISO one per frame, in the order pushed. `resp_ready` is low while the transmit FIFO holds TX_DEPTH (default 4) bytes, and a byte offered then is not taken.
- R5: A frame that starts with the transmit FIFO empty sends the last transmitted byte again (0x00 after reset).
- R6: `host_irq` is high in the cycle after a response byte with `resp_last` high is accepted.
- R7: `host_irq` falls after a frame ends that emptied the transmit FIFO, or in the cycle after `irq_clear`. An accepted byte with `resp_last` high in the same cycle wins over either clear.
- R8: `underrun_flag` sets when a frame starts with the transmit FIFO empty and stays set until `underrun_clear` is pulsed. A new underrun wins over a clear.
- R9: Raising chip select in the middle of a frame discards the partial byte and every byte of the incomplete command, and restarts the 4-byte count. Raising it between whole frames keeps the partial command.
- R10: The receive store holds 8 bytes, counting those of the incomplete command. A byte that arrives when it is full is dropped together with the incomplete command, and `overflow_flag` sets. The flag stays set until `overflow_clear` is pulsed.
- R11: After reset, `spi_miso`, `host_irq`, `cmd_valid` and both flags are 0 and `resp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SPI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from the host, idles low |
| spi_cs_n | input | 1 | Chip select from the host, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| host_irq | output | 1 | High while a response is waiting for the host |
| cmd_valid | output | 1 | A complete command is available |
| cmd_ready | input | 1 | Local logic takes the command |
| cmd_data | output | 32 | Command bytes, first byte in the top byte |
| resp_valid | input | 1 | Local logic offers a response byte |
| resp_ready | output | 1 | Transmit FIFO has room |
| resp_data | input | 8 | Response byte |
| resp_last | input | 1 | Marks the final byte of a response |
| irq_clear | input | 1 | Local request to drop `host_irq` |
| underrun_flag | output | 1 | Sticky: a frame started with nothing queued |
| underrun_clear | input | 1 | Clears `underrun_flag` |
| overflow_flag | output | 1 | Sticky: a received byte was dropped |
| overflow_clear | input | 1 | Clears `overflow_flag` |

## Verification
Some properties are checked on every cycle: MISO moves only after a synchronised rising SCLK edge, a pending command keeps its data until it is taken, the interrupt follows a last-byte push and a local clear, and both flags stay set until they are cleared. A behavioural model in the bench covers the rest. It predicts the byte seen on MISO in every frame, including the replay value on underrun and the interrupt drop at the end of a draining frame. It also predicts the command words that result from chip-select aborts, from pauses between whole frames and from an overflowing receive store.

// File: rtl/spi_resp_pkg.sv
// Shared widths and constants for the SPI command responder.
// Assumes byte-wide SPI frames throughout.
package spi_resp_pkg;
    localparam int unsigned BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
    localparam byte_t REPLAY_INIT = 8'h00;
endpackage

// File: rtl/spi_in_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes STAGES >= 2 and that the bits need no mutual coherence beyond
// what the sampling ratio of the consumer provides.
module spi_in_sync #(
    parameter int            W       = 3,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
// Mode-1 bit engine working on synchronised SPI pins. It detects SCLK
// edges, loads the outgoing byte at a frame's first rising edge (FIFO head,
// or the previous byte when the FIFO is empty), shifts MISO on rising edges
// and MOSI in on falling edges. It also flags a mid-frame chip-select release.
// Assumes the system clock runs at least 8 times faster than SCLK.
module spi_bit_engine #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_s,
    input  logic            cs_n_s,
    input  logic            mosi_s,
    input  logic            tx_empty,
    input  logic [BITS-1:0] tx_head,
    output logic            tx_pop,
    output logic            underrun_evt,
    output logic            rx_valid,
    output logic [BITS-1:0] rx_byte,
    output logic            frame_end_fifo,
    output logic            abort,
    output logic            miso
);
    localparam int CW = $clog2(BITS);

    logic            sclk_q;
    logic [CW-1:0]   bit_cnt;
    logic            loaded;
    logic            from_fifo;
    logic [BITS-1:0] rx_sh;
    logic [BITS-1:0] tx_sh;
    logic [BITS-1:0] last_tx;

    logic            active, rise, fall, load_evt, last_fall;
    logic [BITS-1:0] load_val;

    // Edge detection and frame-start decisions.
    always_comb begin
        active       = !cs_n_s;
        rise         = active && sclk_s && !sclk_q;
        fall         = active && !sclk_s && sclk_q;
        load_evt     = rise && !loaded;
        tx_pop       = load_evt && !tx_empty;
        underrun_evt = load_evt && tx_empty;
        load_val     = tx_empty ? last_tx : tx_head;
        last_fall    = fall && (bit_cnt == CW'(BITS - 1));
        abort        = cs_n_s && ((bit_cnt != '0) || loaded);
    end

    // Remember the previous synchronised SCLK level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    // Bit counting, shift registers and per-frame load state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            loaded    <= 1'b0;
            from_fifo <= 1'b0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            last_tx   <= BITS'(spi_resp_pkg::REPLAY_INIT);
        end else if (!active) begin
            bit_cnt <= '0;
            loaded  <= 1'b0;
        end else begin
            if (rise) begin
                if (!loaded) begin
                    tx_sh     <= load_val;
                    last_tx   <= load_val;
                    loaded    <= 1'b1;
                    from_fifo <= !tx_empty;
                end else begin
                    tx_sh <= {tx_sh[BITS-2:0], 1'b0};
                end
            end
            if (fall) begin
                rx_sh <= {rx_sh[BITS-2:0], mosi_s};
                if (last_fall) begin
                    bit_cnt <= '0;
                    loaded  <= 1'b0;
                end else begin
                    bit_cnt <= bit_cnt + CW'(1);
                end
            end
        end
    end

    // Register the completed byte and the end-of-frame notice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid       <= 1'b0;
            rx_byte        <= '0;
            frame_end_fifo <= 1'b0;
        end else begin
            rx_valid       <= last_fall;
            frame_end_fifo <= last_fall && from_fifo;
            if (last_fall) rx_byte <= {rx_sh[BITS-2:0], mosi_s};
        end
    end

    assign miso = tx_sh[BITS-1];
endmodule

// File: rtl/rx_chunk_fifo.sv
// Receive byte store that releases data in fixed-size commands. Bytes of
// the command still being received sit above a commit pointer. An abort or
// an overflow rolls the write pointer back to it, so partial commands never
// reach the reader. Assumes DEPTH is a power of two and a multiple of CMD_BYTES.
module rx_chunk_fifo #(
    parameter int BITS      = 8,
    parameter int CMD_BYTES = 4,
    parameter int DEPTH     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [BITS-1:0]           in_byte,
    input  logic                      abort,
    input  logic                      ovf_clear,
    output logic                      ovf_flag,
    output logic                      cmd_valid,
    input  logic                      cmd_ready,
    output logic [CMD_BYTES*BITS-1:0] cmd_data
);
    localparam int AW   = $clog2(DEPTH);
    localparam int PW   = AW + 1;
    localparam int CNTW = (CMD_BYTES > 1) ? $clog2(CMD_BYTES) : 1;

    logic [BITS-1:0] mem [DEPTH];
    logic [PW-1:0]   wr_ptr, cm_ptr, rd_ptr;
    logic [CNTW-1:0] part_cnt;
    logic [PW-1:0]   used, committed;
    logic            full, take;

    // Occupancy and handshake terms.
    always_comb begin
        used      = wr_ptr - rd_ptr;
        committed = cm_ptr - rd_ptr;
        full      = (used == PW'(DEPTH));
        cmd_valid = (committed >= PW'(CMD_BYTES));
        take      = cmd_valid && cmd_ready;
    end

    // Store an accepted byte.
    always_ff @(posedge clk) begin
        if (in_valid && !full && !abort) mem[wr_ptr[AW-1:0]] <= in_byte;
    end

    // Pointer, commit and partial-count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            cm_ptr   <= '0;
            rd_ptr   <= '0;
            part_cnt <= '0;
        end else begin
            if (take) rd_ptr <= rd_ptr + PW'(CMD_BYTES);
            if (abort || (in_valid && full)) begin
                wr_ptr   <= cm_ptr;
                part_cnt <= '0;
            end else if (in_valid) begin
                wr_ptr <= wr_ptr + PW'(1);
                if (part_cnt == CNTW'(CMD_BYTES - 1)) begin
                    cm_ptr   <= wr_ptr + PW'(1);
                    part_cnt <= '0;
                end else begin
                    part_cnt <= part_cnt + CNTW'(1);
                end
            end
        end
    end

    // Sticky overflow indication.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ovf_flag <= 1'b0;
        else if (in_valid && full)    ovf_flag <= 1'b1;
        else if (ovf_clear)           ovf_flag <= 1'b0;
    end

    // Present the oldest command, first byte in the top lane.
    for (genvar i = 0; i < CMD_BYTES; i++) begin : g_lane
        logic [AW-1:0] idx;
        assign idx = rd_ptr[AW-1:0] + AW'(i);
        assign cmd_data[(CMD_BYTES-1-i)*BITS +: BITS] = mem[idx];
    end
endmodule

// File: rtl/tx_resp_fifo.sv
// First-word-fall-through FIFO for response bytes.
// Assumes DEPTH is a power of two; push is ignored when full, pop when empty.
module tx_resp_fifo #(
    parameter int BITS  = 8,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [BITS-1:0] push_data,
    input  logic            pop,
    output logic [BITS-1:0] head,
    output logic            empty,
    output logic            full
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [BITS-1:0] mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;

    // Status from pointer distance.
    always_comb begin
        empty = (wr_ptr == rd_ptr);
        full  = ((wr_ptr - rd_ptr) == PW'(DEPTH));
        head  = mem[rd_ptr[AW-1:0]];
    end

    // Write storage.
    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_ptr[AW-1:0]] <= push_data;
    end

    // Pointer movement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push && !full) wr_ptr <= wr_ptr + PW'(1);
            if (pop && !empty) rd_ptr <= rd_ptr + PW'(1);
        end
    end
endmodule

// File: rtl/spi_cmd_responder.sv
// SPI mode-1 slave for a command/response link. It synchronises the SPI
// pins, assembles 4-byte commands for local logic, queues response bytes,
// raises host_irq when a response is complete and keeps a sticky underrun
// flag. Assumes clk runs at least 8 times faster than SCLK.
module spi_cmd_responder
    import spi_resp_pkg::*;
#(
    parameter int CMD_BYTES   = 4,
    parameter int RX_DEPTH    = 8,
    parameter int TX_DEPTH    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        spi_sclk,
    input  logic                        spi_cs_n,
    input  logic                        spi_mosi,
    output logic                        spi_miso,
    output logic                        host_irq,
    output logic                        cmd_valid,
    input  logic                        cmd_ready,
    output logic [CMD_BYTES*BYTE_W-1:0] cmd_data,
    input  logic                        resp_valid,
    output logic                        resp_ready,
    input  logic [BYTE_W-1:0]           resp_data,
    input  logic                        resp_last,
    input  logic                        irq_clear,
    output logic                        underrun_flag,
    input  logic                        underrun_clear,
    output logic                        overflow_flag,
    input  logic                        overflow_clear
);
    logic  sclk_s, cs_n_s, mosi_s;
    logic  tx_pop, tx_empty, tx_full, push;
    byte_t tx_head, rx_byte;
    logic  underrun_evt, rx_valid, frame_end_fifo, abort;

    spi_in_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_cs_n, spi_sclk, spi_mosi}),
        .q     ({cs_n_s, sclk_s, mosi_s})
    );

    spi_bit_engine #(
        .BITS (BYTE_W)
    ) u_engine (
        .clk            (clk),
        .rst_n          (rst_n),
        .sclk_s         (sclk_s),
        .cs_n_s         (cs_n_s),
        .mosi_s         (mosi_s),
        .tx_empty       (tx_empty),
        .tx_head        (tx_head),
        .tx_pop         (tx_pop),
        .underrun_evt   (underrun_evt),
        .rx_valid       (rx_valid),
        .rx_byte        (rx_byte),
        .frame_end_fifo (frame_end_fifo),
        .abort          (abort),
        .miso           (spi_miso)
    );

    rx_chunk_fifo #(
        .BITS      (BYTE_W),
        .CMD_BYTES (CMD_BYTES),
        .DEPTH     (RX_DEPTH)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .in_byte   (rx_byte),
        .abort     (abort),
        .ovf_clear (overflow_clear),
        .ovf_flag  (overflow_flag),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_data  (cmd_data)
    );

    tx_resp_fifo #(
        .BITS  (BYTE_W),
        .DEPTH (TX_DEPTH)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (resp_data),
        .pop       (tx_pop),
        .head      (tx_head),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    assign resp_ready = !tx_full;
    assign push       = resp_valid && !tx_full;

    // Interrupt to the host: set by a completed response, dropped by a
    // draining frame or a local clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          host_irq <= 1'b0;
        else if (push && resp_last)                          host_irq <= 1'b1;
        else if (irq_clear || (frame_end_fifo && tx_empty && !push))
                                                             host_irq <= 1'b0;
    end

    // Sticky underrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n)              underrun_flag <= 1'b0;
        else if (underrun_evt)   underrun_flag <= 1'b1;
        else if (underrun_clear) underrun_flag <= 1'b0;
    end
endmodule

// File: rtl/spi_cmd_responder_chk.sv
// Property checker for spi_cmd_responder, attached with bind.
module spi_cmd_responder_chk #(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          spi_miso,
    input logic          sclk_s,
    input logic          host_irq,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [CW-1:0] cmd_data,
    input logic          resp_valid,
    input logic          resp_ready,
    input logic          resp_last,
    input logic          irq_clear,
    input logic          underrun_flag,
    input logic          underrun_clear,
    input logic          overflow_flag,
    input logic          overflow_clear
);
    AST_MISO_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_miso) |-> ($past(sclk_s) && !$past(sclk_s, 2))); // R1
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data))); // R3
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_ready && resp_last) |=> host_irq); // R6
    AST_IRQ_ROSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> $past(resp_valid && resp_ready && resp_last)); // R6
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear && !(resp_valid && resp_ready && resp_last)) |=> !host_irq); // R7
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_flag && !underrun_clear) |=> underrun_flag); // R8
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_flag && !overflow_clear) |=> overflow_flag); // R10
endmodule

bind spi_cmd_responder spi_cmd_responder_chk #(
    .CW (CMD_BYTES * spi_resp_pkg::BYTE_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .spi_miso       (spi_miso),
    .sclk_s         (sclk_s),
    .host_irq       (host_irq),
    .cmd_valid      (cmd_valid),
    .cmd_ready      (cmd_ready),
    .cmd_data       (cmd_data),
    .resp_valid     (resp_valid),
    .resp_ready     (resp_ready),
    .resp_last      (resp_last),
    .irq_clear      (irq_clear),
    .underrun_flag  (underrun_flag),
    .underrun_clear (underrun_clear),
    .overflow_flag  (overflow_flag),
    .overflow_clear (overflow_clear)
);

// File: tb/spi_cmd_responder_bench.sv
`timescale 1ns/1ps
module spi_cmd_responder_bench;
    localparam int TXD = 4;
    localparam int RXD = 8;
    localparam int H   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic        spi_miso, host_irq, cmd_valid, resp_ready;
    logic        underrun_flag, overflow_flag;
    logic [31:0] cmd_data;
    logic        cmd_ready = 1'b0, resp_valid = 1'b0, resp_last = 1'b0;
    logic [7:0]  resp_data = 8'h00;
    logic        irq_clear = 1'b0, underrun_clear = 1'b0, overflow_clear = 1'b0;

    always #2.5 clk = ~clk;

    spi_cmd_responder u_spi_cmd_responder (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .host_irq(host_irq),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
        .resp_last(resp_last), .irq_clear(irq_clear),
        .underrun_flag(underrun_flag), .underrun_clear(underrun_clear),
        .overflow_flag(overflow_flag), .overflow_clear(overflow_clear)
    );

    // Behavioural reference state.
    logic [7:0]  tx_q[$];
    logic [7:0]  part_q[$];
    logic [31:0] cmd_q[$];
    logic [7:0]  m_last = 8'h00;
    bit          m_irq = 0, m_und = 0, m_ovf = 0;
    bit          busy = 1, mon_en = 0, done = 0;
    int          n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every idle clock against the model.
    always @(negedge clk) begin
        if (mon_en && !busy && !done) begin
            chk(host_irq === m_irq, "R7 irq", 32'(host_irq), 32'(m_irq));
            chk(underrun_flag === m_und, "R8 underrun", 32'(underrun_flag), 32'(m_und));
            chk(overflow_flag === m_ovf, "R10 overflow", 32'(overflow_flag), 32'(m_ovf));
            chk(cmd_valid === (cmd_q.size() > 0), "R3 cmd_valid",
                32'(cmd_valid), 32'(cmd_q.size() > 0));
            if (cmd_q.size() > 0)
                chk(cmd_data === cmd_q[0], "R3 cmd_data", cmd_data, cmd_q[0]);
            chk(resp_ready === (tx_q.size() < TXD), "R4 resp_ready",
                32'(resp_ready), 32'(tx_q.size() < TXD));
        end
    end

    function automatic void model_rx(input logic [7:0] b);
        if (cmd_q.size() * 4 + part_q.size() >= RXD) begin
            m_ovf = 1;
            part_q.delete();
        end else begin
            part_q.push_back(b);
            if (part_q.size() == 4) begin
                cmd_q.push_back({part_q[0], part_q[1], part_q[2], part_q[3]});
                part_q.delete();
            end
        end
    endfunction

    function automatic logic [7:0] model_load(output bit from_fifo);
        logic [7:0] v;
        if (tx_q.size() == 0) begin
            m_und = 1; from_fifo = 0; v = m_last;
        end else begin
            v = tx_q.pop_front(); from_fifo = 1;
        end
        m_last = v;
        return v;
    endfunction

    task automatic cs_sel();
        busy = 1; spi_cs_n = 1'b0;
        repeat (H) @(negedge clk);
        busy = 0;
    endtask

    task automatic cs_desel();
        busy = 1; spi_cs_n = 1'b1;
        repeat (H) @(negedge clk);
        busy = 0;
    endtask

    // One full mode-1 frame from the host side; checks the byte seen on MISO.
    task automatic spi_byte(input logic [7:0] mo, input string tag);
        logic [7:0] mi, exp;
        bit from;
        busy = 1;
        exp = model_load(from);
        for (int i = 7; i >= 0; i--) begin
            spi_sclk = 1'b1; spi_mosi = mo[i];
            repeat (H) @(negedge clk);
            mi[i] = spi_miso;
            spi_sclk = 1'b0;
            repeat (H) @(negedge clk);
        end
        model_rx(mo);
        if (from && tx_q.size() == 0) m_irq = 0;
        chk(mi === exp, tag, 32'(mi), 32'(exp));
        busy = 0;
    endtask

    // Partial frame of k bits, then chip select released (R9).
    task automatic spi_abort(input int k);
        bit from;
        logic [7:0] unused;
        busy = 1;
        unused = model_load(from);
        for (int i = 0; i < k; i++) begin
            spi_sclk = 1'b1; spi_mosi = 1'b1;
            repeat (H) @(negedge clk);
            spi_sclk = 1'b0;
            repeat (H) @(negedge clk);
        end
        spi_cs_n = 1'b1;
        repeat (H) @(negedge clk);
        part_q.delete();
        busy = 0;
    endtask

    task automatic push(input logic [7:0] b, input bit last, input bit clr);
        bit acc;
        @(negedge clk);
        resp_valid = 1'b1; resp_data = b; resp_last = last; irq_clear = clr;
        @(posedge clk); #1;
        acc = (tx_q.size() < TXD);
        if (acc) tx_q.push_back(b);
        if (clr) m_irq = 0;
        if (acc && last) m_irq = 1;
        @(negedge clk);
        resp_valid = 1'b0; resp_last = 1'b0; irq_clear = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: underrun_clear = 1'b1;
            1: overflow_clear = 1'b1;
            2: irq_clear = 1'b1;
            default: cmd_ready = 1'b1;
        endcase
        @(posedge clk); #1;
        case (which)
            0: m_und = 0;
            1: m_ovf = 0;
            2: m_irq = 0;
            default: if (cmd_q.size() > 0) void'(cmd_q.pop_front());
        endcase
        @(negedge clk);
        underrun_clear = 1'b0; overflow_clear = 1'b0; irq_clear = 1'b0; cmd_ready = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(spi_miso === 1'b0, "R11 miso", 32'(spi_miso), 0);
        chk(host_irq === 1'b0, "R11 irq", 32'(host_irq), 0);
        chk(cmd_valid === 1'b0, "R11 cmd_valid", 32'(cmd_valid), 0);
        chk({underrun_flag, overflow_flag} === 2'b00, "R11 flags",
            32'({underrun_flag, overflow_flag}), 0);
        chk(resp_ready === 1'b1, "R11 resp_ready", 32'(resp_ready), 1);
        busy = 0; mon_en = 1;

        // R3 R5 R8: command bytes with nothing queued; replay of 0x00
        cs_sel();
        spi_byte(8'h11, "R5 replay");
        spi_byte(8'h22, "R5 replay");
        spi_byte(8'h33, "R5 replay");
        spi_byte(8'hA5, "R2 frame");
        cs_desel();
        pulse(0);
        pulse(3);

        // R4 R6 R7: two-byte reply, irq drops after the draining frame
        push(8'hA5, 0, 0);
        push(8'h3C, 1, 0);
        cs_sel();
        spi_byte(8'h00, "R4 order");
        spi_byte(8'h00, "R4 order");
        spi_byte(8'h00, "R5 replay last");
        cs_desel();
        pulse(0);

        // R9: release between whole frames keeps the partial command
        cs_sel();
        spi_byte(8'h5A, "R1 mode1");
        cs_desel();
        pulse(3);

        // R9: mid-frame release discards the incomplete command
        cs_sel();
        spi_byte(8'h77, "R1 mode1");
        spi_abort(3);
        cs_sel();
        for (int b = 1; b <= 8; b++) spi_byte(8'(b), "R1 mode1");
        // R10: ninth byte overflows the store
        spi_byte(8'h09, "R10 drop");
        spi_byte(8'h0A, "R10 drop");
        cs_desel();
        pulse(1);
        pulse(3);
        pulse(3);

        // R4: full transmit FIFO refuses a fifth byte
        push(8'hC1, 0, 0);
        push(8'hC2, 0, 0);
        push(8'hC3, 0, 0);
        push(8'hC4, 1, 0);
        push(8'hEE, 1, 0);
        // R7: local clear
        pulse(2);
        cs_sel();
        spi_byte(8'h00, "R4 order");
        cs_desel();
        // R7: set wins over a simultaneous clear
        push(8'hC5, 1, 1);
        cs_sel();
        for (int b = 0; b < 4; b++) spi_byte(8'h00, "R4 drain");
        spi_byte(8'h00, "R5 replay last");
        cs_desel();
        pulse(0);
        pulse(3);
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule